// File: doc/BRIEF.md
# ECC Error Capture Register

This block sits next to the ECC checker of a memory controller and keeps a record of the first memory error the checker reports. The checker supplies a one-cycle pulse for a corrected (single-bit) error and a one-cycle pulse for an uncorrectable (multi-bit) error. Each pulse comes with the failing byte address and the 8-bit syndrome. When the block is idle, the first such event is latched: a type flag, the upper part of the address, and the syndrome. Every event after that is ignored until software acknowledges the record.

Software uses a single 32-bit word, read through a combinational read port and written through a one-cycle write strobe. The word holds three control bits:
- an NMI enable for single-bit errors,
- a system-error enable for multi-bit errors,
- a scrub-disable bit.

When scrubbing is left enabled, capturing a single-bit error also sends a one-cycle scrub request to the memory controller, carrying the base address of the affected region.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset, the read word is 0, and `nmi_req`, `serr_req` and `scrub_req` are 0. A zero scrub-disable bit means scrubbing starts out enabled.
- R2: With both flags clear, a `ce_pulse` without `ue_pulse` sets the read word as follows, starting the cycle after the capturing edge:
  - bit 0 (single-bit flag) = 1 and bit 1 = 0;
  - bits 30:12 = `err_addr[31:13]`, so each record covers an 8 KiB region;
  - bits 11:4 = `err_syn`.
- R3: With both flags clear, a `ue_pulse` sets bit 1 (multi-bit flag) and clears bit 0, and captures the address and syndrome in the same fields as R2. A `ce_pulse` in the same cycle does not change this: the multi-bit error is recorded.
- R4: While bit 0 or bit 1 is set, further error pulses are dropped:
  - bits 30:0 stay unchanged;
  - the flag of the type that arrived later stays 0.
- R5: A write clears both flags only if it carries 1 in bit 1 and in bit 0 together. A write with only one of the two bits set, or with neither, leaves both flags unchanged.
- R6: Bits 31, 3 and 2 are loaded from every write and read back unchanged. Writes do not alter bits 30:4.
- R7: `nmi_req` is 1 exactly while bit 0 is set and bit 2 (NMI enable) is 1.
- R8: `serr_req` is 1 exactly while bit 1 is set and bit 3 (system-error enable) is 1.
- R9: Capturing a single-bit error while bit 31 (scrub disable) is 0 raises `scrub_req` for exactly one cycle, the cycle right after the capturing edge. During that cycle `scrub_addr` = `{err_addr[31:13], 13'b0}`. No scrub request follows a multi-bit capture, a capture made while bit 31 is 1, or a dropped error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_pulse | input | 1 | Corrected (single-bit) error event, one cycle |
| ue_pulse | input | 1 | Uncorrectable (multi-bit) error event, one cycle |
| err_addr | input | 32 | Byte address of the failing access |
| err_syn | input | 8 | ECC syndrome of the failing access |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| nmi_req | output | 1 | NMI request level for a logged single-bit error |
| serr_req | output | 1 | System-error request level for a logged multi-bit error |
| scrub_req | output | 1 | One-cycle scrub request for a corrected location |
| scrub_addr | output | 32 | Region base address to scrub |

## Verification
Faults in the capture state show up on `reg_rdata` one cycle after the edge that should have caught or dropped an event:
- a lost or double capture appears as a wrong flag pair;
- a record that is not frozen appears as address or syndrome bits that move under a second pulse;
- a clear that ignores the two-bit rule leaves the flags set, or empties them early.

A wrong scrub decision appears the same cycle on `scrub_req`: a missing, extra or two-cycle pulse, or a wrong region base on `scrub_addr`. The notification levels follow the flags with no delay, so an enable that is mis-latched shows up on `nmi_req` or `serr_req` as soon as the record is set.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 32;
  localparam int PTR_W   = 19;
  localparam int SYN_W   = 8;
  localparam int GRAIN_W = ADDR_W - PTR_W;

  // register layout, low to high
  localparam int SBE_BIT       = 0;
  localparam int MBE_BIT       = 1;
  localparam int NMI_EN_BIT    = 2;
  localparam int SERR_EN_BIT   = 3;
  localparam int SYN_LSB       = 4;
  localparam int PTR_LSB       = SYN_LSB + SYN_W;
  localparam int SCRUB_DIS_BIT = PTR_LSB + PTR_W;

  typedef struct packed {
    logic scrub_dis;
    logic serr_en;
    logic nmi_en;
  } ctrl_t;

  // region pointer taken from a byte address
  function automatic logic [PTR_W-1:0] addr_to_ptr(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: PTR_W];
  endfunction

  // base byte address of the region named by a pointer
  function automatic logic [ADDR_W-1:0] ptr_to_base(input logic [PTR_W-1:0] p);
    return {p, {GRAIN_W{1'b0}}};
  endfunction

  function automatic logic [REG_W-1:0] pack_word(input ctrl_t c,
                                                 input logic [PTR_W-1:0] p,
                                                 input logic [SYN_W-1:0] s,
                                                 input logic mbe,
                                                 input logic sbe);
    logic [REG_W-1:0] w;
    w = '0;
    w[SCRUB_DIS_BIT]             = c.scrub_dis;
    w[PTR_LSB +: PTR_W]          = p;
    w[SYN_LSB +: SYN_W]          = s;
    w[SERR_EN_BIT]               = c.serr_en;
    w[NMI_EN_BIT]                = c.nmi_en;
    w[MBE_BIT]                   = mbe;
    w[SBE_BIT]                   = sbe;
    return w;
  endfunction
endpackage

// File: rtl/ecc_cap_ctrl.sv
module ecc_cap_ctrl
  import ecc_cap_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output ctrl_t         ctrl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q.scrub_dis <= wdata[SCRUB_DIS_BIT];
      ctrl_q.serr_en   <= wdata[SERR_EN_BIT];
      ctrl_q.nmi_en    <= wdata[NMI_EN_BIT];
    end
  end

  // R6: control bits move only on a write
  a_r6_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));

  // R6: a write lands its control bits
  a_r6_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctrl_q.scrub_dis == $past(wdata[SCRUB_DIS_BIT]));
endmodule

// File: rtl/ecc_cap_log.sv
module ecc_cap_log
  import ecc_cap_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int SW = SYN_W,
  parameter int DW = REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             ue,
  input  logic [AW-1:0]    addr,
  input  logic [SW-1:0]    syn,
  input  logic             wr_en,
  input  logic [DW-1:0]    wdata,
  output logic             sbe_q,
  output logic             mbe_q,
  output logic [PTR_W-1:0] ptr_q,
  output logic [SW-1:0]    syn_q,
  output logic             cap_sbe
);
  logic busy;
  logic take;
  logic clr_hit;

  assign busy    = sbe_q | mbe_q;
  assign take    = !busy && (ce || ue);
  assign clr_hit = wr_en && wdata[MBE_BIT] && wdata[SBE_BIT];
  assign cap_sbe = take && !ue;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sbe_q <= 1'b0;
      mbe_q <= 1'b0;
      ptr_q <= '0;
      syn_q <= '0;
    end else if (take) begin
      mbe_q <= ue;
      sbe_q <= !ue;
      ptr_q <= addr_to_ptr(addr);
      syn_q <= syn;
    end else if (clr_hit) begin
      sbe_q <= 1'b0;
      mbe_q <= 1'b0;
    end
  end

  // R2: lone corrected error while idle
  a_r2_sbe_capture: assert property (@(posedge clk) disable iff (!rst_n)
    take && !ue |=> sbe_q && !mbe_q && ptr_q == addr_to_ptr($past(addr)));

  // R3: multi-bit wins, including a same-cycle pair
  a_r3_mbe_wins: assert property (@(posedge clk) disable iff (!rst_n)
    take && ue |=> mbe_q && !sbe_q);

  // R4: record frozen while logged unless a full clear arrives
  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !clr_hit |=> $stable(ptr_q) && $stable(syn_q) && $stable({mbe_q, sbe_q}));

  // R4: never both flags
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sbe_q && mbe_q));

  // R5: full clear empties a held record
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    busy && clr_hit |=> !sbe_q && !mbe_q);
endmodule

// File: rtl/ecc_cap_notify.sv
module ecc_cap_notify
  import ecc_cap_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_sbe,
  input  ctrl_t            ctrl,
  input  logic             sbe_q,
  input  logic             mbe_q,
  input  logic [PTR_W-1:0] ptr_q,
  output logic             nmi_req,
  output logic             serr_req,
  output logic             scrub_req,
  output logic [AW-1:0]    scrub_addr
);
  logic scrub_q;

  always_ff @(posedge clk) begin
    if (!rst_n) scrub_q <= 1'b0;
    else        scrub_q <= cap_sbe && !ctrl.scrub_dis;
  end

  assign scrub_req  = scrub_q;
  assign scrub_addr = ptr_to_base(ptr_q);
  assign nmi_req    = sbe_q && ctrl.nmi_en;
  assign serr_req   = mbe_q && ctrl.serr_en;

  // R9: single cycle strobe
  a_r9_scrub_single: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_req |=> !scrub_req);

  // R9: only with a single-bit record present
  a_r9_scrub_sbe_only: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_req |-> sbe_q && !mbe_q);

  // R9: follows a capture made with scrubbing enabled
  a_r9_scrub_cause: assert property (@(posedge clk) disable iff (!rst_n)
    cap_sbe && !ctrl.scrub_dis |=> scrub_req);
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_pulse,
  input  logic              ue_pulse,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [SYN_W-1:0]  err_syn,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              nmi_req,
  output logic              serr_req,
  output logic              scrub_req,
  output logic [ADDR_W-1:0] scrub_addr
);
  ctrl_t             ctrl_q;
  logic              sbe_q;
  logic              mbe_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [SYN_W-1:0]  syn_q;
  logic              cap_sbe;

  ecc_cap_ctrl #(.DW(REG_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_we),
    .wdata  (reg_wdata),
    .ctrl_q (ctrl_q)
  );

  ecc_cap_log #(.AW(ADDR_W), .SW(SYN_W), .DW(REG_W)) u_log (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce      (ce_pulse),
    .ue      (ue_pulse),
    .addr    (err_addr),
    .syn     (err_syn),
    .wr_en   (reg_we),
    .wdata   (reg_wdata),
    .sbe_q   (sbe_q),
    .mbe_q   (mbe_q),
    .ptr_q   (ptr_q),
    .syn_q   (syn_q),
    .cap_sbe (cap_sbe)
  );

  ecc_cap_notify #(.AW(ADDR_W)) u_notify (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_sbe    (cap_sbe),
    .ctrl       (ctrl_q),
    .sbe_q      (sbe_q),
    .mbe_q      (mbe_q),
    .ptr_q      (ptr_q),
    .nmi_req    (nmi_req),
    .serr_req   (serr_req),
    .scrub_req  (scrub_req),
    .scrub_addr (scrub_addr)
  );

  assign reg_rdata = pack_word(ctrl_q, ptr_q, syn_q, mbe_q, sbe_q);

  // R7: NMI level implies a single-bit record visible in the word
  a_r7_nmi_word: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> reg_rdata[SBE_BIT] && reg_rdata[NMI_EN_BIT]);

  // R8: system-error level implies a multi-bit record visible in the word
  a_r8_serr_word: assert property (@(posedge clk) disable iff (!rst_n)
    serr_req |-> reg_rdata[MBE_BIT] && reg_rdata[SERR_EN_BIT]);
endmodule

// File: tb/tb_ecc_err_capture.sv
`timescale 1ns/1ps
module tb_ecc_err_capture;
  localparam real CLK_NS = 4.0;
  localparam int  NV     = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_pulse, ue_pulse;
  logic [31:0] err_addr;
  logic [7:0]  err_syn;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        nmi_req, serr_req, scrub_req;
  logic [31:0] scrub_addr;

  int checks = 0;
  int errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  ecc_err_capture dut (
    .clk(clk), .rst_n(rst_n), .ce_pulse(ce_pulse), .ue_pulse(ue_pulse),
    .err_addr(err_addr), .err_syn(err_syn), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_req(nmi_req),
    .serr_req(serr_req), .scrub_req(scrub_req), .scrub_addr(scrub_addr)
  );

  localparam logic [31:0] V_CTRL [NV] = '{32'h0000_0000, 32'h8000_0000, 32'h0000_0004,
                                          32'h0000_0008, 32'h0000_000C, 32'h0000_0004};
  localparam logic        V_CE   [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic        V_UE   [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [31:0] V_ADDR [NV] = '{32'h1234_5678, 32'hFFFF_E000, 32'h0000_2000,
                                          32'h8000_1FFF, 32'hDEAD_BEEF, 32'h0001_0000};
  localparam logic [7:0]  V_SYN  [NV] = '{8'h3C, 8'hA5, 8'h01, 8'hFF, 8'h5A, 8'h77};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic inject(input logic ce, input logic ue, input logic [31:0] a, input logic [7:0] s);
    @(negedge clk);
    ce_pulse = ce; ue_pulse = ue; err_addr = a; err_syn = s;
    @(negedge clk);
    ce_pulse = 1'b0; ue_pulse = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    rst_n = 1'b0; ce_pulse = 0; ue_pulse = 0; err_addr = '0; err_syn = '0;
    reg_we = 0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 word", reg_rdata, 32'h0);
    chk("R1 outputs", {29'h0, nmi_req, serr_req, scrub_req}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic mbe, sbe;
      logic [31:0] exp;
      mbe = V_UE[i];
      sbe = V_CE[i] & ~V_UE[i];
      exp = (V_CTRL[i] & 32'h8000_000C) | ((V_ADDR[i] >> 13) << 12)
            | (32'(V_SYN[i]) << 4) | {30'h0, mbe, sbe};
      wr(V_CTRL[i]);
      inject(V_CE[i], V_UE[i], V_ADDR[i], V_SYN[i]);
      chk(mbe ? "R3 word" : "R2 word", reg_rdata, exp);
      chk("R7 nmi", 32'(nmi_req), 32'(sbe & V_CTRL[i][2]));
      chk("R8 serr", 32'(serr_req), 32'(mbe & V_CTRL[i][3]));
      chk("R9 scrub", 32'(scrub_req), 32'(sbe & ~V_CTRL[i][31]));
      if (scrub_req) chk("R9 scrub_addr", scrub_addr, V_ADDR[i] & 32'hFFFF_E000);
      @(negedge clk);
      chk("R9 scrub width", 32'(scrub_req), 32'h0);
      wr(V_CTRL[i] | 32'h3);
      chk("R5 cleared", reg_rdata & 32'h3, 32'h0);
      chk("R6 ctrl kept", reg_rdata & 32'h8000_000C, V_CTRL[i] & 32'h8000_000C);
    end

    // drop of later errors
    wr(32'h0000_0004);
    inject(1'b1, 1'b0, 32'h4000_6000, 8'h11);
    held = reg_rdata;
    inject(1'b0, 1'b1, 32'h0BAD_0000, 8'h99);
    chk("R4 frozen after ue", reg_rdata, held);
    chk("R4 no late scrub", 32'(scrub_req), 32'h0);
    inject(1'b1, 1'b0, 32'h0777_0000, 8'h22);
    chk("R4 frozen after ce", reg_rdata, held);
    chk("R4 no second scrub", 32'(scrub_req), 32'h0);

    // partial clears
    wr(32'h0000_0005);
    chk("R5 bit0 only", reg_rdata, held);
    wr(32'h0000_0006);
    chk("R5 bit1 only", reg_rdata, held);
    wr(32'h0000_0004);
    chk("R5 zero write", reg_rdata, held);
    wr(32'h0000_0007);
    chk("R5 full clear", reg_rdata & 32'h3, 32'h0);
    chk("R7 nmi drops", 32'(nmi_req), 32'h0);

    // read-only field protection
    wr(32'hFFFF_FFFC);
    chk("R6 ro fields", reg_rdata, (held & 32'h7FFF_FFF0) | 32'h8000_000C);

    // scrub-disabled capture of a single-bit error
    inject(1'b1, 1'b0, 32'h0000_4000, 8'h42);
    chk("R9 disabled", 32'(scrub_req), 32'h0);
    chk("R7 nmi on", 32'(nmi_req), 32'h1);

    // reset mid-record
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset word", reg_rdata, 32'h0);
    chk("R1 reset outputs", {29'h0, nmi_req, serr_req, scrub_req}, 32'h0);

    finish_run();
  end
endmodule